// File: doc/BRIEF.md
# Receive Comma Byte Aligner

This block sits between a serial deserializer and an 8b/10b decoder. It receives one raw 10-bit code group per cycle of the recovered receive clock. These groups carry no symbol framing. The block keeps the current group and the previous one in a 20-bit window and compares every bit offset against the two 7-bit comma patterns. When an enabled comma turns up at a new offset, it moves its barrel-shift offset there, so that every later group it passes on is a correctly framed symbol.

The framed symbols are packed into an output word of one, two or four 10-bit lanes. The earliest symbol goes into the top lane. A lane flag marks each lane that holds a comma, and it is valid together with the word-valid pulse. A parameter selects upper-lane placement. With it set, a comma that would land in a lane an odd number of positions below the top lane restarts the packing instead. With it clear, commas land wherever the stream puts them.

The two comma enables are retimed in the receive clock domain before use. Clearing both freezes the alignment.

Top module: `comma_aligner`

## Requirements
- R1: While reset is high, and after it is released, word_o, comma_lane_o, word_vld_o and realign_o are zero. word_o stays zero until the first word_vld_o pulse. The shift offset starts at zero.
- R2: When an enabled comma appears at an offset other than the current one, the offset moves there and realign_o is high for one cycle. From that comma onward the lanes carry the transmitted symbols with correct framing.
- R3: A comma at the current offset raises the flag of the lane that holds it, and realign_o stays low.
- R4: The negative comma is 0011111 and the positive comma is 1100000, each read as the first seven bits of a symbol (bit 9 first). With only en_neg_i high, only the negative comma can realign. With only en_pos_i high, only the positive comma can realign. With both low, the offset is frozen and a comma at another offset is not flagged.
- R5: Each enable passes through one register in the receive clock domain. An enable raised in the last cycle in which a comma is fully inside the window does not cause a realignment.
- R6: Symbols are packed top lane first. Lane i occupies bits [10i+9:10i], and lane LANES-1 holds the earliest symbol of the word. word_vld_o is a one-cycle pulse per completed word.
- R7: With MSB_LANE=1, a flagged comma only ever sits in lane LANES-1 or lane LANES-3. In a 4-lane word this is lane 3 or lane 1, and the lane flag says which one.
- R8: With MSB_LANE=1, a comma that arrives when an odd number of lanes is already filled discards the partial word and starts a new word with the comma in the top lane.
- R9: With MSB_LANE=0, packing never restarts, so a comma may land in any lane, including lane 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered receive clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_grp_i | input | GW | Raw unframed code group, bit GW-1 received first |
| en_pos_i | input | 1 | Allow realignment on the positive-disparity comma |
| en_neg_i | input | 1 | Allow realignment on the negative-disparity comma |
| word_o | output | LANES*GW | Packed output word of framed symbols |
| comma_lane_o | output | LANES | Per-lane comma flag, valid with word_vld_o |
| word_vld_o | output | 1 | One-cycle pulse when word_o is updated |
| realign_o | output | 1 | One-cycle pulse when the shift offset changes |

## Verification
The bench builds two copies of the block that share one input stream. The first has four lanes with upper-lane placement on. It reaches the lane 3 or lane 1 comma positions and the discarded partial word on restart, and a scoreboard checks it word by word against a packing model. The second has two lanes with placement off, which lets a comma fall into lane 0. The bench changes the skew of the serial stream between phases. It drives each enable combination, and it raises an enable in the same cycle as the last view of a comma, so that the retiming register can be observed at the ports.

// File: rtl/cma_pkg.sv
package cma_pkg;
  localparam int COMMA_W = 7;
  localparam logic [COMMA_W-1:0] NEG_COMMA = 7'b0011111;
  localparam logic [COMMA_W-1:0] POS_COMMA = 7'b1100000;
endpackage

// File: rtl/cma_en_sync.sv
module cma_en_sync #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  always_ff @(posedge clk) begin
    if (rst) q_o <= '0;
    else     q_o <= d_i;
  end
endmodule

// File: rtl/cma_window_scan.sv
module cma_window_scan #(
  parameter int GW = 10
) (
  input  logic [2*GW-1:0] win_i,
  output logic [GW-1:0]   neg_at_o,
  output logic [GW-1:0]   pos_at_o
);
  import cma_pkg::*;

  // one comparator pair per candidate bit offset
  for (genvar k = 0; k < GW; k++) begin : g_off
    localparam int TOP = 2*GW-1-k;
    assign neg_at_o[k] = (win_i[TOP -: COMMA_W] == NEG_COMMA);
    assign pos_at_o[k] = (win_i[TOP -: COMMA_W] == POS_COMMA);
  end
endmodule

// File: rtl/cma_frame_shift.sv
module cma_frame_shift #(
  parameter int GW = 10,
  localparam int OW = $clog2(GW)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [GW-1:0] grp_i,
  input  logic          en_pos,
  input  logic          en_neg,
  output logic [GW-1:0] sym_o,
  output logic          sym_comma_o,
  output logic          sym_vld_o,
  output logic          realign_o
);
  logic [2*GW-1:0] win_q;
  logic [1:0]      fill_q;
  logic [OW-1:0]   off_q;
  logic [GW-1:0]   neg_at, pos_at, en_hit;
  logic [OW-1:0]   pick, eff;
  logic            at_cur, move, full;
  logic [GW-1:0]   sym_c;
  logic            cm_c;

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q  <= '0;
      fill_q <= '0;
    end else begin
      win_q <= {win_q[GW-1:0], grp_i};
      if (fill_q != 2'd2) fill_q <= fill_q + 2'd1;
    end
  end

  assign full = (fill_q == 2'd2);

  cma_window_scan #(.GW(GW)) u_scan (
    .win_i    (win_q),
    .neg_at_o (neg_at),
    .pos_at_o (pos_at)
  );

  assign en_hit = (neg_at & {GW{en_neg}}) | (pos_at & {GW{en_pos}});

  always_comb begin
    pick   = '0;
    at_cur = 1'b0;
    for (int k = GW-1; k >= 0; k--) begin
      if (en_hit[k]) pick = OW'(k);
    end
    for (int k = 0; k < GW; k++) begin
      if (off_q == OW'(k)) at_cur = en_hit[k];
    end
    move = full && (|en_hit) && !at_cur;
    eff  = move ? pick : off_q;
    sym_c = '0;
    cm_c  = 1'b0;
    for (int k = 0; k < GW; k++) begin
      if (eff == OW'(k)) begin
        sym_c = win_q[2*GW-1-k -: GW];
        cm_c  = neg_at[k] | pos_at[k];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      off_q       <= '0;
      realign_o   <= 1'b0;
      sym_o       <= '0;
      sym_comma_o <= 1'b0;
      sym_vld_o   <= 1'b0;
    end else begin
      off_q       <= eff;
      realign_o   <= move;
      sym_o       <= sym_c;
      sym_comma_o <= cm_c && full;
      sym_vld_o   <= full;
    end
  end

  // R2: a realign pulse always comes with a new offset
  a_r2_realign_moves: assert property (@(posedge clk) disable iff (rst)
    realign_o |-> (off_q != $past(off_q)));

  // R4: with both retimed enables low the offset holds
  a_r4_frozen: assert property (@(posedge clk) disable iff (rst)
    (!en_pos && !en_neg) |=> $stable(off_q));
endmodule

// File: rtl/cma_lane_packer.sv
module cma_lane_packer #(
  parameter int GW       = 10,
  parameter int LANES    = 2,
  parameter bit MSB_LANE = 1'b1,
  localparam int CW = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [GW-1:0]       sym_i,
  input  logic                sym_comma_i,
  input  logic                sym_vld_i,
  output logic [LANES*GW-1:0] word_o,
  output logic [LANES-1:0]    comma_lane_o,
  output logic                word_vld_o
);
  function automatic logic [LANES-1:0] odd_below_top();
    logic [LANES-1:0] m;
    for (int i = 0; i < LANES; i++) m[i] = (((LANES-1-i) % 2) == 1);
    return m;
  endfunction
  localparam logic [LANES-1:0] BAD_LANES = odd_below_top();

  logic [CW-1:0]       cnt_q, base;
  logic [LANES*GW-1:0] acc_q, acc_n;
  logic [LANES-1:0]    fl_q, fl_n;
  logic                restart, last;

  always_comb begin
    restart = (MSB_LANE != 1'b0) && (LANES > 1) && sym_comma_i && cnt_q[0];
    base    = restart ? '0 : cnt_q;
    acc_n   = restart ? '0 : acc_q;
    fl_n    = restart ? '0 : fl_q;
    for (int i = 0; i < LANES; i++) begin
      if (base == CW'(LANES-1-i)) begin
        acc_n[i*GW +: GW] = sym_i;
        fl_n[i]           = sym_comma_i;
      end
    end
    last = (base == CW'(LANES-1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q        <= '0;
      acc_q        <= '0;
      fl_q         <= '0;
      word_o       <= '0;
      comma_lane_o <= '0;
      word_vld_o   <= 1'b0;
    end else begin
      word_vld_o   <= 1'b0;
      comma_lane_o <= '0;
      if (sym_vld_i) begin
        if (last) begin
          word_o       <= acc_n;
          comma_lane_o <= fl_n;
          word_vld_o   <= 1'b1;
          cnt_q        <= '0;
          acc_q        <= '0;
          fl_q         <= '0;
        end else begin
          cnt_q <= base + 1'b1;
          acc_q <= acc_n;
          fl_q  <= fl_n;
        end
      end
    end
  end

  // R6: with several lanes, completed words are never back to back
  a_r6_vld_spaced: assert property (@(posedge clk) disable iff (rst)
    (LANES > 1 && word_vld_o) |=> !word_vld_o);

  // R7: upper-lane placement keeps commas out of odd-below-top lanes
  a_r7_msb_lanes: assert property (@(posedge clk) disable iff (rst)
    (MSB_LANE && word_vld_o) |-> ((comma_lane_o & BAD_LANES) == '0));

  // R1: no lane flag outside a word pulse
  a_r1_flags_gated: assert property (@(posedge clk) disable iff (rst)
    !word_vld_o |-> (comma_lane_o == '0));
endmodule

// File: rtl/comma_aligner.sv
module comma_aligner #(
  parameter int GW       = 10,
  parameter int LANES    = 2,
  parameter bit MSB_LANE = 1'b1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [GW-1:0]       rx_grp_i,
  input  logic                en_pos_i,
  input  logic                en_neg_i,
  output logic [LANES*GW-1:0] word_o,
  output logic [LANES-1:0]    comma_lane_o,
  output logic                word_vld_o,
  output logic                realign_o
);
  logic [1:0]    en_q;
  logic [GW-1:0] sym;
  logic          sym_comma, sym_vld;

  cma_en_sync #(.N(2)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({en_pos_i, en_neg_i}),
    .q_o (en_q)
  );

  cma_frame_shift #(.GW(GW)) u_shift (
    .clk         (clk),
    .rst         (rst),
    .grp_i       (rx_grp_i),
    .en_pos      (en_q[1]),
    .en_neg      (en_q[0]),
    .sym_o       (sym),
    .sym_comma_o (sym_comma),
    .sym_vld_o   (sym_vld),
    .realign_o   (realign_o)
  );

  cma_lane_packer #(.GW(GW), .LANES(LANES), .MSB_LANE(MSB_LANE)) u_pack (
    .clk          (clk),
    .rst          (rst),
    .sym_i        (sym),
    .sym_comma_i  (sym_comma),
    .sym_vld_i    (sym_vld),
    .word_o       (word_o),
    .comma_lane_o (comma_lane_o),
    .word_vld_o   (word_vld_o)
  );

  // R5: a realignment needs an enable that was present two edges earlier
  a_r5_retimed_enable: assert property (@(posedge clk) disable iff (rst)
    realign_o |-> $past(en_pos_i || en_neg_i, 2));
endmodule

// File: tb/tb_comma_aligner.sv
`timescale 1ns/1ps
module tb_comma_aligner;
  localparam logic [9:0] CNEG = 10'b0011111010;
  localparam logic [9:0] CPOS = 10'b1100000101;
  localparam logic [9:0] D1 = 10'h2AA, D2 = 10'h155, D3 = 10'h25A, D4 = 10'h1A5;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst, en_p, en_n;
  logic [9:0]  grp;
  logic [39:0] w4; logic [3:0] f4; logic v4, ra4;
  logic [19:0] w2; logic [1:0] f2; logic v2, ra2;

  comma_aligner #(.GW(10), .LANES(4), .MSB_LANE(1'b1)) dut (
    .clk(clk), .rst(rst), .rx_grp_i(grp), .en_pos_i(en_p), .en_neg_i(en_n),
    .word_o(w4), .comma_lane_o(f4), .word_vld_o(v4), .realign_o(ra4));

  comma_aligner #(.GW(10), .LANES(2), .MSB_LANE(1'b0)) dut_lsb (
    .clk(clk), .rst(rst), .rx_grp_i(grp), .en_pos_i(en_p), .en_neg_i(en_n),
    .word_o(w2), .comma_lane_o(f2), .word_vld_o(v2), .realign_o(ra2));

  int checks = 0, fails = 0, cyc = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_up();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", checks, fails);
    $finish;
  endtask

  // scoreboard model of the packing rules (R6, R7, R8)
  logic [39:0] q_w[$];
  logic [3:0]  q_f[$];
  int m_cnt = 0;
  logic [39:0] m_acc = '0;
  logic [3:0]  m_fl = '0;

  task automatic model_push(input logic [9:0] s);
    bit k;
    k = (s == CNEG) || (s == CPOS);
    if (k && (m_cnt % 2 == 1)) begin
      m_cnt = 0; m_acc = '0; m_fl = '0;
    end
    m_acc[(3-m_cnt)*10 +: 10] = s;
    m_fl[3-m_cnt] = k;
    m_cnt++;
    if (m_cnt == 4) begin
      q_w.push_back(m_acc);
      q_f.push_back(m_fl);
      m_cnt = 0; m_acc = '0; m_fl = '0;
    end
  endtask

  // driver: serial stream framed with a chosen skew
  int skew = 0;
  logic [9:0] prev_s = '0;
  logic en_p_nx = 1'b0, en_n_nx = 1'b0;

  task automatic send(input logic [9:0] s, input bit trk);
    logic [19:0] pr;
    pr = {prev_s, s};
    @(negedge clk);
    grp  = pr[19:0] >> skew;
    en_p = en_p_nx;
    en_n = en_n_nx;
    prev_s = s;
    if (trk) model_push(s);
  endtask

  task automatic send_data(input int n);
    for (int i = 0; i < n; i++) send(((i % 2) == 0) ? D3 : D4, 1'b0);
  endtask

  // monitor
  bit hunting = 1'b0;
  int cmp_cnt = 0, ra_cnt = 0, flag_cnt = 0, seen_l1 = 0, seen_lsb0 = 0;

  always @(negedge clk) begin
    if (!rst && !done) begin
      if (ra4) ra_cnt++;
      if (v4) begin
        if (|f4) flag_cnt++;
        if (f4[1]) seen_l1++;
        chk((f4 & 4'b0101) == 4'b0, "R7", "comma in lane 2 or 0", {60'b0, f4}, 64'b0);
        if (hunting && f4[3]) hunting = 1'b0;
        if (!hunting && q_w.size() > 0) begin
          logic [39:0] ew; logic [3:0] ef;
          ew = q_w.pop_front();
          ef = q_f.pop_front();
          cmp_cnt++;
          chk(w4 == ew, "R6 R2", "word", {24'b0, w4}, {24'b0, ew});
          chk(f4 == ef, "R8 R3", "lane flags", {60'b0, f4}, {60'b0, ef});
        end
      end
      if (v2) begin
        for (int i = 0; i < 2; i++) begin
          if (f2[i]) begin
            chk((w2[i*10 +: 10] == CNEG) || (w2[i*10 +: 10] == CPOS), "R9",
                "flagged lane holds comma", {54'b0, w2[i*10 +: 10]}, {54'b0, CNEG});
          end
        end
        if (f2[0]) seen_lsb0++;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000 && !done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=%0d expected=<100000 cycles", cyc);
      finish_up();
    end
  end

  int rb, fb;

  initial begin
    rst = 1'b1; grp = '0; en_p = 1'b0; en_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(w4 == 0 && f4 == 0 && !v4 && !ra4, "R1", "outputs in reset",
        {24'b0, w4}, 64'b0);
    rst = 1'b0;
    @(negedge clk); @(negedge clk);
    chk(w4 == 0 && !v4 && !ra4, "R1", "outputs after reset", {24'b0, w4}, 64'b0);

    // Phase A: both enables, skew 3, scoreboard on the 4-lane copy
    skew = 3; en_p_nx = 1'b1; en_n_nx = 1'b1;
    send_data(8);
    rb = ra_cnt; fb = flag_cnt;
    hunting = 1'b1;
    send(CNEG, 1'b0);
    send(CPOS, 1'b1); send(D1, 1'b1); send(D2, 1'b1); send(D3, 1'b1);
    send(D4, 1'b1); send(D1, 1'b1); send(CNEG, 1'b1); send(D2, 1'b1);
    send(D1, 1'b1); send(CPOS, 1'b1); send(D2, 1'b1); send(D3, 1'b1); send(D4, 1'b1);
    send_data(12);
    chk(ra_cnt - rb == 1, "R2", "realign pulses phase A", ra_cnt - rb, 1);
    chk(flag_cnt - fb >= 3, "R3", "flagged words phase A", flag_cnt - fb, 3);
    chk(cmp_cnt == 3 && q_w.size() == 0, "R8", "words compared", cmp_cnt, 3);
    chk(seen_l1 > 0, "R7", "comma seen in lane 1", seen_l1, 1);
    chk(seen_lsb0 > 0, "R9", "comma seen in lane 0 without placement", seen_lsb0, 1);

    // Phase B: enables off, new skew -> frozen
    en_p_nx = 1'b0; en_n_nx = 1'b0; skew = 7;
    rb = ra_cnt; fb = flag_cnt;
    send_data(6); send(CNEG, 1'b0); send_data(6); send(CPOS, 1'b0); send_data(10);
    chk(ra_cnt == rb, "R4", "realign with enables off", ra_cnt - rb, 0);
    chk(flag_cnt == fb, "R4", "flags at foreign offset", flag_cnt - fb, 0);

    // Phase C: negative-only, then positive-only
    en_n_nx = 1'b1;
    rb = ra_cnt;
    send_data(4); send(CPOS, 1'b0); send_data(8);
    chk(ra_cnt == rb, "R4", "positive comma with negative-only enable", ra_cnt - rb, 0);
    send(CNEG, 1'b0); send_data(8);
    chk(ra_cnt - rb == 1, "R4", "negative comma realigns", ra_cnt - rb, 1);
    en_n_nx = 1'b0; en_p_nx = 1'b1; skew = 2;
    rb = ra_cnt;
    send_data(4); send(CNEG, 1'b0); send_data(8);
    chk(ra_cnt == rb, "R4", "negative comma with positive-only enable", ra_cnt - rb, 0);
    send(CPOS, 1'b0); send_data(8);
    chk(ra_cnt - rb == 1, "R4", "positive comma realigns", ra_cnt - rb, 1);

    // Phase D: enable raised in the last cycle the comma is in the window
    en_p_nx = 1'b0; en_n_nx = 1'b0; skew = 5;
    send_data(6);
    rb = ra_cnt;
    send(CNEG, 1'b0); send(D1, 1'b0);
    en_p_nx = 1'b1; en_n_nx = 1'b1;
    send(D2, 1'b0); send_data(8);
    chk(ra_cnt == rb, "R5", "late enable ignored", ra_cnt - rb, 0);
    send(CNEG, 1'b0); send_data(8);
    chk(ra_cnt - rb == 1, "R5", "retimed enable acts on next comma", ra_cnt - rb, 1);

    finish_up();
  end
endmodule